// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches finished address translations for a processor core. Each entry holds one offset word (physical address minus virtual address) and three independent tags, one each for instruction fetch, data load and data store. A translation can therefore be valid for one access kind and absent for another, and the permission decisions made elsewhere stay separate per kind. The page table walk and the permission checks sit outside the block: it only keeps the results it is handed on its refill port.

A lookup presents a virtual address and an access kind. One clock later the block reports hit or miss and, on a hit, the translated address. A refill presents a virtual address, the physical address it maps to and the access kind. It writes that kind's tag and the shared offset, and it clears any other kind's tag at the same entry that belongs to a different page. A flush input clears every tag.

Top module: `tlb_split`

## Requirements
- R1: After reset every tag is invalid and every lookup misses, including one whose page number is all ones.
- R2: The entry index is the low log2(ENTRIES) bits of the virtual page number (address bits above the 12-bit page offset), and the full page number is the tag. A lookup with a different page number at the same index misses.
- R3: Access kind codes are 0 fetch, 1 load, 2 store, with code 3 handled as load. A lookup hits only when the tag of its own kind at its index is valid and equals its page number.
- R4: A refill leaves the tags of other kinds at its index unchanged when they hold the same page number as the refill.
- R5: A refill invalidates the tags of other kinds at its index when they hold a different page number, and it validates only the tag of its own kind.
- R6: On a hit, rspPaddr equals the looked-up virtual address plus (refill physical address minus refill virtual address), modulo 2^VA_W. On a miss rspPaddr is zero.
- R7: A flush invalidates all tags of all three kinds.
- R8: When flush and a refill come in the same cycle, the flush wins and the refill has no effect.
- R9: rspValid is lkValid delayed by one cycle. The response reflects the tag state after any refill or flush of the cycle in which the request was registered. rspHit is 0 whenever rspValid is 0.
- R10: A page number of all ones can be refilled and then hits. It does not hit while invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all tags |
| lkValid | input | 1 | Lookup request strobe |
| lkKind | input | 2 | Lookup access kind |
| lkVaddr | input | VA_W | Lookup virtual address |
| rfValid | input | 1 | Refill strobe |
| rfKind | input | 2 | Refill access kind |
| rfVaddr | input | VA_W | Refill virtual address |
| rfPaddr | input | VA_W | Refill physical address |
| rspValid | output | 1 | Lookup response valid |
| rspHit | output | 1 | Lookup hit |
| rspPaddr | output | VA_W | Translated address, zero on miss |

## Verification
Directed sequences refill one kind and then look the page up under all three kinds, which shows the tags are separate. A same-page refill of a second kind shows that tags are kept (R4), and a different-page refill at the same index shows that they are dropped (R5). Flush alone, flush together with a refill, an all-ones page with an offset that wraps around, and a neighbouring index each isolate one corner. A random phase over a small page range forces frequent index aliasing and mixes lookups, refills and flushes in the same cycle. A cycle-by-cycle model is compared against hit and address on every clock.

// File: rtl/tlb_split_pkg.sv
package tlb_split_pkg;
  localparam int unsigned NUM_KINDS = 3;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2
  } accKind_e;

  typedef struct packed {
    logic       flushAll;
    logic       writeOffs;
    logic [2:0] setTag;
    logic [2:0] dropTag;
  } tagCmd_t;

  function automatic logic [2:0] kindSel(input logic [1:0] kind);
    case (kind)
      2'd0:    kindSel = 3'b001;
      2'd2:    kindSel = 3'b100;
      default: kindSel = 3'b010;
    endcase
  endfunction
endpackage

// File: rtl/tlb_split_ctrl.sv
module tlb_split_ctrl
  import tlb_split_pkg::*;
(
  input  logic       flush,
  input  logic       rfValid,
  input  logic [1:0] rfKind,
  input  logic [2:0] rfMatch,
  input  logic [1:0] lkKind,
  output tagCmd_t    cmd,
  output logic [2:0] lkSel
);
  logic       refillGo;
  logic [2:0] rfSel;

  always_comb begin
    refillGo      = rfValid & ~flush;
    rfSel         = kindSel(rfKind);
    cmd.flushAll  = flush;
    cmd.writeOffs = refillGo;
    cmd.setTag    = refillGo ? rfSel : 3'b000;
    cmd.dropTag   = refillGo ? (~rfSel & ~rfMatch) : 3'b000;
    lkSel         = kindSel(lkKind);
  end
endmodule

// File: rtl/tlb_split_dpath.sv
module tlb_split_dpath
  import tlb_split_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  tagCmd_t         cmd,
  input  logic [VA_W-1:0] rfVaddr,
  input  logic [VA_W-1:0] rfPaddr,
  output logic [2:0]      rfMatch,
  input  logic            lkValid,
  input  logic [2:0]      lkSel,
  input  logic [VA_W-1:0] lkVaddr,
  output logic            rspValid,
  output logic            rspHit,
  output logic [VA_W-1:0] rspPaddr
);
  localparam int unsigned VPN_W = VA_W - PG_SHIFT;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0] rfVpn;
  logic [IDX_W-1:0] rfIdx;
  logic [VA_W-1:0]  rspVa;
  logic [2:0]       rspSel;
  logic [VPN_W-1:0] rspVpn;
  logic [IDX_W-1:0] rspIdx;
  logic [2:0]       hitVec;
  logic [VA_W-1:0]  offsMem [ENTRIES];

  assign rfVpn  = rfVaddr[VA_W-1:PG_SHIFT];
  assign rfIdx  = rfVpn[IDX_W-1:0];
  assign rspVpn = rspVa[VA_W-1:PG_SHIFT];
  assign rspIdx = rspVpn[IDX_W-1:0];

  for (genvar k = 0; k < NUM_KINDS; k++) begin : gKind
    logic [ENTRIES-1:0] vldBits;
    logic [VPN_W-1:0]   tagMem [ENTRIES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldBits <= '0;
        for (int e = 0; e < ENTRIES; e++) tagMem[e] <= '1;
      end else if (cmd.flushAll) begin
        vldBits <= '0;
        for (int e = 0; e < ENTRIES; e++) tagMem[e] <= '1;
      end else if (cmd.setTag[k]) begin
        vldBits[rfIdx] <= 1'b1;
        tagMem[rfIdx]  <= rfVpn;
      end else if (cmd.dropTag[k]) begin
        vldBits[rfIdx] <= 1'b0;
        tagMem[rfIdx]  <= '1;
      end
    end

    assign rfMatch[k] = vldBits[rfIdx] && (tagMem[rfIdx] == rfVpn);
    assign hitVec[k]  = vldBits[rspIdx] && (tagMem[rspIdx] == rspVpn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) offsMem[e] <= '0;
    end else if (cmd.writeOffs) begin
      offsMem[rfIdx] <= rfPaddr - rfVaddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspVa    <= '0;
      rspSel   <= '0;
    end else begin
      rspValid <= lkValid;
      if (lkValid) begin
        rspVa  <= lkVaddr;
        rspSel <= lkSel;
      end
    end
  end

  assign rspHit   = rspValid && |(rspSel & hitVec);
  assign rspPaddr = rspHit ? (rspVa + offsMem[rspIdx]) : '0;
endmodule

// File: rtl/tlb_split.sv
module tlb_split
  import tlb_split_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic            lkValid,
  input  logic [1:0]      lkKind,
  input  logic [VA_W-1:0] lkVaddr,
  input  logic            rfValid,
  input  logic [1:0]      rfKind,
  input  logic [VA_W-1:0] rfVaddr,
  input  logic [VA_W-1:0] rfPaddr,
  output logic            rspValid,
  output logic            rspHit,
  output logic [VA_W-1:0] rspPaddr
);
  tagCmd_t    cmd;
  logic [2:0] rfMatch;
  logic [2:0] lkSel;

  tlb_split_ctrl uCtrl (
    .flush(flush), .rfValid(rfValid), .rfKind(rfKind), .rfMatch(rfMatch),
    .lkKind(lkKind), .cmd(cmd), .lkSel(lkSel)
  );

  tlb_split_dpath #(.VA_W(VA_W), .ENTRIES(ENTRIES), .PG_SHIFT(PG_SHIFT)) uDpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rfVaddr(rfVaddr), .rfPaddr(rfPaddr),
    .rfMatch(rfMatch), .lkValid(lkValid), .lkSel(lkSel), .lkVaddr(lkVaddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspPaddr(rspPaddr)
  );
endmodule

// File: rtl/tlb_split_chk.sv
module tlb_split_chk #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PG_SHIFT = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            flush,
  input logic            lkValid,
  input logic [1:0]      lkKind,
  input logic [VA_W-1:0] lkVaddr,
  input logic            rfValid,
  input logic [1:0]      rfKind,
  input logic [VA_W-1:0] rfVaddr,
  input logic [VA_W-1:0] rfPaddr,
  input logic            rspValid,
  input logic            rspHit,
  input logic [VA_W-1:0] rspPaddr
);
  logic samePage;
  assign samePage = lkVaddr[VA_W-1:PG_SHIFT] == rfVaddr[VA_W-1:PG_SHIFT];

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid); // R9
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid); // R9
  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rstN)
    flush && lkValid |=> !rspHit); // R7
  AST_FLUSH_BEATS_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    flush && rfValid && lkValid && samePage && lkKind == rfKind |=> !rspHit); // R8
  AST_REFILL_HITS: assert property (@(posedge clk) disable iff (!rstN)
    rfValid && !flush && lkValid && samePage && lkKind == rfKind |=> rspHit); // R3
  AST_REFILL_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rfValid && !flush && lkValid && samePage && lkKind == rfKind
      |=> rspPaddr == $past(lkVaddr + (rfPaddr - rfVaddr))); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> rspPaddr == '0); // R6
endmodule

bind tlb_split tlb_split_chk #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) uChk (
  .clk(clk), .rstN(rstN), .flush(flush), .lkValid(lkValid), .lkKind(lkKind),
  .lkVaddr(lkVaddr), .rfValid(rfValid), .rfKind(rfKind), .rfVaddr(rfVaddr),
  .rfPaddr(rfPaddr), .rspValid(rspValid), .rspHit(rspHit), .rspPaddr(rspPaddr)
);

// File: tb/tb_tlb_split.sv
module tb_tlb_split;
  localparam int unsigned VA_W = 32;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned PG_SHIFT = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, lkValid = 1'b0, rfValid = 1'b0;
  logic [1:0] lkKind = '0, rfKind = '0;
  logic [VA_W-1:0] lkVaddr = '0, rfVaddr = '0, rfPaddr = '0;
  logic rspValid, rspHit;
  logic [VA_W-1:0] rspPaddr;

  int testsRun = 0, testsFailed = 0, cycles = 0;
  bit done = 0;
  string phase = "R1";

  // reference: per kind, a map from entry index to cached page (valid when present)
  longint pageOf [3][int];
  logic [VA_W-1:0] offOf [int];
  bit expValid = 0, expHit = 0;
  logic [VA_W-1:0] expAddr = '0;

  tlb_split #(.VA_W(VA_W), .ENTRIES(ENTRIES), .PG_SHIFT(PG_SHIFT)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .lkValid(lkValid), .lkKind(lkKind),
    .lkVaddr(lkVaddr), .rfValid(rfValid), .rfKind(rfKind), .rfVaddr(rfVaddr),
    .rfPaddr(rfPaddr), .rspValid(rspValid), .rspHit(rspHit), .rspPaddr(rspPaddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int kindNum(logic [1:0] k);
    return (k == 2'd3) ? 1 : int'(k);
  endfunction

  task automatic modelEdge();
    longint pg;
    int idx;
    int rk;
    if (flush) begin
      for (int k = 0; k < 3; k++) pageOf[k].delete();
    end else if (rfValid) begin
      pg = longint'(rfVaddr >> PG_SHIFT);
      idx = int'(pg % ENTRIES);
      rk = kindNum(rfKind);
      for (int k = 0; k < 3; k++)
        if (pageOf[k].exists(idx) && pageOf[k][idx] != pg) pageOf[k].delete(idx);
      pageOf[rk][idx] = pg;
      offOf[idx] = rfPaddr - rfVaddr;
    end
    expValid = lkValid;
    expHit = 0;
    expAddr = '0;
    if (lkValid) begin
      pg = longint'(lkVaddr >> PG_SHIFT);
      idx = int'(pg % ENTRIES);
      rk = kindNum(lkKind);
      if (pageOf[rk].exists(idx) && pageOf[rk][idx] == pg) begin
        expHit = 1;
        expAddr = lkVaddr + offOf[idx];
      end
    end
  endtask

  task automatic compare();
    testsRun++;
    if (rspValid !== expValid || rspHit !== expHit || rspPaddr !== expAddr) begin
      testsFailed++;
      $display("FAIL %s: got valid=%0b hit=%0b paddr=%h, expected valid=%0b hit=%0b paddr=%h",
               phase, rspValid, rspHit, rspPaddr, expValid, expHit, expAddr);
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare();
    flush = 0; rfValid = 0; lkValid = 0;
  endtask

  task automatic look(logic [1:0] k, logic [VA_W-1:0] va);
    lkValid = 1; lkKind = k; lkVaddr = va;
    step();
  endtask

  task automatic fill(logic [1:0] k, logic [VA_W-1:0] va, logic [VA_W-1:0] pa);
    rfValid = 1; rfKind = k; rfVaddr = va; rfPaddr = pa;
    step();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        testsFailed++;
        $display("FAIL watchdog: got %0d cycles, expected under 100000", cycles);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    phase = "R1";
    testsRun++;
    if (rspValid !== 0 || rspHit !== 0) begin
      testsFailed++;
      $display("FAIL R1: got valid=%0b hit=%0b, expected 0 0", rspValid, rspHit);
    end
    for (int k = 0; k < 3; k++) look(k[1:0], 32'h1234_5678);
    phase = "R10";
    look(2'd2, 32'hFFFF_F123);
    // R3 kinds are separate
    phase = "R3";
    fill(2'd0, 32'h0040_3abc, 32'h8000_7abc);
    look(2'd0, 32'h0040_3010);
    look(2'd1, 32'h0040_3010);
    look(2'd2, 32'h0040_3010);
    look(2'd3, 32'h0040_3010);
    // R6 translated address
    phase = "R6";
    look(2'd0, 32'h0040_3ffc);
    // R4 same page keeps other tags
    phase = "R4";
    fill(2'd3, 32'h0040_3000, 32'h9000_0000);
    look(2'd0, 32'h0040_3020);
    look(2'd1, 32'h0040_3020);
    // R2 neighbour index and aliasing page
    phase = "R2";
    fill(2'd1, 32'h0040_4000, 32'h0000_1000);
    look(2'd1, 32'h0041_3020);
    look(2'd1, 32'h0040_4abc);
    // R5 different page drops other kinds
    phase = "R5";
    fill(2'd2, 32'h0041_3000, 32'h0002_2000);
    look(2'd0, 32'h0040_3020);
    look(2'd1, 32'h0040_3020);
    look(2'd2, 32'h0041_3444);
    look(2'd1, 32'h0040_4abc);
    // R7 flush
    phase = "R7";
    flush = 1; step();
    look(2'd2, 32'h0041_3444);
    look(2'd1, 32'h0040_4abc);
    // R8 flush beats refill
    phase = "R8";
    flush = 1; fill(2'd0, 32'h0050_0000, 32'h0060_0000);
    look(2'd0, 32'h0050_0000);
    // R10 all-ones page with wrapping offset
    phase = "R10";
    fill(2'd2, 32'hFFFF_F000, 32'h0000_5000);
    look(2'd2, 32'hFFFF_F7f0);
    look(2'd1, 32'hFFFF_F7f0);
    // R9 lookup in same cycle as refill sees the refill
    phase = "R9";
    rfValid = 1; rfKind = 2'd1; rfVaddr = 32'h0070_2000; rfPaddr = 32'h0010_0000;
    look(2'd1, 32'h0070_2008);
    step();
    // random mix, small page range for heavy aliasing
    phase = "R3";
    for (int i = 0; i < 2000; i++) begin
      flush = ($urandom_range(0, 40) == 0);
      rfValid = $urandom_range(0, 1);
      rfKind = 2'($urandom_range(0, 3));
      rfVaddr = (32'($urandom_range(0, 40)) << PG_SHIFT) | 32'($urandom_range(0, 4095));
      rfPaddr = $urandom;
      lkValid = $urandom_range(0, 3) != 0;
      lkKind = 2'($urandom_range(0, 3));
      lkVaddr = (32'($urandom_range(0, 40)) << PG_SHIFT) | 32'($urandom_range(0, 4095));
      step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule